// File: doc/BRIEF.md
# Boot Mode Entry Sequence Detector

This block sits beside a processor's reset logic and decides, each time the external active-low reset input is released, where the processor begins fetching. With the watched pin low at release, the ordinary start address 0xFFFE is issued. A deliberate pattern on a second pin while reset is held low selects the bootloader vector instead. The pattern is two rising transitions, each one made of levels that last long enough, with the pin still high when reset rises.

Both external pins arrive asynchronously. Each passes through a two-flop synchronizer before any edge detection. One shared counter measures how long the current level of the watched pin has lasted. It restarts on every edge of that pin and whenever reset falls. Minimum durations are parameters in clock cycles; at 100 MHz, for example, 250 ns becomes 25. A configuration input chooses whether the watched pin is the test input or an alternate enable input. The decision comes out as a one-cycle strobe, together with a boot-select flag and a 16-bit start address. The flag and the address hold their values until the next decision.

Top module: `boot_entry_detector`

## Requirements
- R1: When the synchronized reset input rises while the watched pin is low, the block pulses `dec_stb` with `boot_sel`=0 and `start_addr`=0xFFFE (USER_VEC). The strobe is visible in the third clock cycle after the raw reset input rises.
- R2: The bootloader path is taken only if all three conditions hold at reset release: at least two qualified rising edges were counted, the watched pin is high, and its current high level has lasted at least MIN_LEVEL_CYC cycles. Otherwise R1 applies.
- R3: When the bootloader path is taken, no strobe is issued at reset release. The strobe, with `boot_sel`=1 and `start_addr`=BOOT_VEC, appears in the third cycle after the raw watched pin next goes low.
- R4: A rising edge counts only if the low level before it lasted at least MIN_LEVEL_CYC cycles. A falling edge ending any high level after the first one needs that high level to have lasted at least MIN_LEVEL_CYC. A failed check clears the rising-edge count to zero.
- R5: The high level after the first counted rising edge must last at least FIRST_HIGH_CYC cycles, or its falling edge clears the count.
- R6: With `use_alt`=1 the alternate enable input is the watched pin and the test input is ignored. With `use_alt`=0 the roles are swapped.
- R7: A falling edge on the reset input clears the rising-edge count and cancels any bootloader decision still waiting for the pin to go low.
- R8: After a decision, edges on the watched pin while reset stays high cause no strobe, and `boot_sel` and `start_addr` keep their values.
- R9: `dec_stb` lasts exactly one cycle. After the block reset, `dec_stb`=0, `boot_sel`=0 and `start_addr`=USER_VEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's own registers |
| ext_rst_n | input | 1 | External active-low reset pin being watched (asynchronous) |
| test_in | input | 1 | Test pin (asynchronous) |
| alt_en_in | input | 1 | Alternate enable pin (asynchronous) |
| use_alt | input | 1 | 1: watch `alt_en_in`; 0: watch `test_in` |
| dec_stb | output | 1 | One-cycle decision strobe |
| boot_sel | output | 1 | 1 = bootloader vector chosen |
| start_addr | output | 16 | Chosen start address |

## Verification
Every result passes through two synchronizer flops and one decision register. A strobe is therefore due in the third cycle after the raw input change that causes it: reset release for the normal path, the watched pin falling for the bootloader path. The bench drives inputs on falling clock edges and samples on falling edges. It requires the strobe to be absent at the first and second samples, present at the third, and gone at the fourth. Level lengths are set in whole cycles, and the synchronizers keep those lengths intact. The boundary cases are one cycle below and exactly at each minimum.

// File: rtl/boot_entry_detector.sv
module boot_entry_detector #(
  parameter int          MIN_LEVEL_CYC  = 25,
  parameter int          FIRST_HIGH_CYC = 100,
  parameter logic [15:0] BOOT_VEC       = 16'h1000,
  parameter logic [15:0] USER_VEC       = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_rst_n,
  input  logic        test_in,
  input  logic        alt_en_in,
  input  logic        use_alt,
  output logic        dec_stb,
  output logic        boot_sel,
  output logic [15:0] start_addr
);
  localparam int CMAX = (MIN_LEVEL_CYC > FIRST_HIGH_CYC) ? MIN_LEVEL_CYC : FIRST_HIGH_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {ARMED, HOLD, DONE} state_t;

  logic [1:0]    rst_sy, test_sy, alt_sy;
  logic          rst_q, pin_q;
  logic [CW-1:0] cnt;
  logic [1:0]    rise_cnt;
  state_t        state;

  wire rst_s    = rst_sy[1];
  wire pin_s    = use_alt ? alt_sy[1] : test_sy[1];
  wire rst_rise = rst_s & ~rst_q;
  wire rst_fall = ~rst_s & rst_q;
  wire pin_rise = pin_s & ~pin_q;
  wire pin_fall = ~pin_s & pin_q;
  wire pin_edge = pin_rise | pin_fall;
  wire low_ok   = cnt >= CW'(MIN_LEVEL_CYC);
  wire first_ok = cnt >= CW'(FIRST_HIGH_CYC);
  wire high_ok  = (rise_cnt == 2'd1) ? first_ok : low_ok;
  wire go_boot  = (rise_cnt == 2'd2) && pin_s && !pin_edge && low_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sy     <= '0;
      test_sy    <= '0;
      alt_sy     <= '0;
      rst_q      <= 1'b0;
      pin_q      <= 1'b0;
      cnt        <= '0;
      rise_cnt   <= '0;
      state      <= ARMED;
      dec_stb    <= 1'b0;
      boot_sel   <= 1'b0;
      start_addr <= USER_VEC;
    end else begin
      rst_sy  <= {rst_sy[0], ext_rst_n};
      test_sy <= {test_sy[0], test_in};
      alt_sy  <= {alt_sy[0], alt_en_in};
      rst_q   <= rst_s;
      pin_q   <= pin_s;
      dec_stb <= 1'b0;

      if (rst_fall || pin_edge) cnt <= CW'(1);
      else if (cnt != CW'(CMAX)) cnt <= cnt + CW'(1);

      unique case (state)
        ARMED: begin
          if (rst_rise) begin
            if (go_boot) state <= HOLD;
            else begin
              dec_stb    <= 1'b1;
              boot_sel   <= 1'b0;
              start_addr <= USER_VEC;
              state      <= DONE;
            end
          end else if (pin_rise) begin
            if (!low_ok) rise_cnt <= 2'd0;
            else if (rise_cnt != 2'd2) rise_cnt <= rise_cnt + 2'd1;
          end else if (pin_fall && !high_ok) begin
            rise_cnt <= 2'd0;
          end
        end
        HOLD: begin
          if (rst_fall) begin
            rise_cnt <= 2'd0;
            state    <= ARMED;
          end else if (!pin_s) begin
            dec_stb    <= 1'b1;
            boot_sel   <= 1'b1;
            start_addr <= BOOT_VEC;
            state      <= DONE;
          end
        end
        default: begin
          if (rst_fall) begin
            rise_cnt <= 2'd0;
            state    <= ARMED;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_entry_detector_chk.sv
module boot_entry_detector_chk #(
  parameter logic [15:0] BOOT_VEC = 16'h1000,
  parameter logic [15:0] USER_VEC = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_s,
  input logic        pin_s,
  input logic [1:0]  rise_cnt,
  input logic        dec_stb,
  input logic        boot_sel,
  input logic [15:0] start_addr
);
  p_addr_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |-> start_addr == (boot_sel ? BOOT_VEC : USER_VEC));

  p_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |-> $past(rst_s));

  p_boot_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && boot_sel) |-> !$past(pin_s));

  p_clear_on_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_s) |=> rise_cnt == 2'd0);

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(start_addr) || !$stable(boot_sel)) |-> dec_stb);

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |=> !dec_stb);
endmodule

bind boot_entry_detector boot_entry_detector_chk #(
  .BOOT_VEC(BOOT_VEC),
  .USER_VEC(USER_VEC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_s      (rst_s),
  .pin_s      (pin_s),
  .rise_cnt   (rise_cnt),
  .dec_stb    (dec_stb),
  .boot_sel   (boot_sel),
  .start_addr (start_addr)
);

// File: tb/boot_entry_detector_tb_top.sv
`timescale 1ns/1ps
module boot_entry_detector_tb_top;
  localparam int          MINL  = 4;
  localparam int          FIRST = 7;
  localparam logic [15:0] BOOTV = 16'h1000;
  localparam logic [15:0] USERV = 16'hFFFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst_n = 1'b0;
  logic test_in = 1'b0;
  logic alt_en_in = 1'b0;
  logic use_alt = 1'b0;
  logic dec_stb, boot_sel;
  logic [15:0] start_addr;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  boot_entry_detector #(
    .MIN_LEVEL_CYC(MINL), .FIRST_HIGH_CYC(FIRST), .BOOT_VEC(BOOTV), .USER_VEC(USERV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .test_in(test_in),
    .alt_en_in(alt_en_in), .use_alt(use_alt), .dec_stb(dec_stb),
    .boot_sel(boot_sel), .start_addr(start_addr)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_pin(input logic v);
    if (use_alt) alt_en_in = v; else test_in = v;
  endtask

  task automatic expect_strobe(input logic sel, input logic [15:0] addr, input string tag);
    for (int i = 0; i < 2; i++) begin
      step(1);
      chk(dec_stb == 1'b0, {tag, " early strobe"}, dec_stb, 0);
    end
    step(1);
    chk(dec_stb == 1'b1, {tag, " strobe"}, dec_stb, 1);
    chk(boot_sel == sel, {tag, " boot_sel"}, boot_sel, sel);
    chk(start_addr == addr, {tag, " start_addr"}, start_addr, addr);
    step(1);
    chk(dec_stb == 1'b0, "R9 strobe width", dec_stb, 0);
  endtask

  task automatic prep(input logic alt);
    ext_rst_n = 1'b0; test_in = 1'b0; alt_en_in = 1'b0; use_alt = alt;
    step(6);
  endtask

  task automatic boot_pattern();
    drive_pin(1); step(FIRST);
    drive_pin(0); step(MINL);
    drive_pin(1); step(MINL);
  endtask

  task automatic t_reset_state();
    step(1);
    chk(dec_stb == 0, "R9 reset strobe", dec_stb, 0);
    chk(boot_sel == 0, "R9 reset boot_sel", boot_sel, 0);
    chk(start_addr == USERV, "R9 reset start_addr", start_addr, USERV);
  endtask

  task automatic t_normal();
    prep(0);
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R1 normal");
  endtask

  task automatic t_boot();
    prep(0);
    boot_pattern();
    ext_rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(dec_stb == 0, "R3 no strobe before pin low", dec_stb, 0);
    end
    drive_pin(0);
    expect_strobe(1, BOOTV, "R3 boot");
  endtask

  task automatic t_one_rise();
    prep(0);
    test_in = 1'b1; step(8);
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R2 single rise");
  endtask

  task automatic t_short_first();
    prep(0);
    test_in = 1'b1; step(FIRST - 1);
    test_in = 1'b0; step(MINL);
    test_in = 1'b1; step(MINL);
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R5 short first high");
  endtask

  task automatic t_short_low();
    prep(0);
    test_in = 1'b1; step(FIRST);
    test_in = 1'b0; step(MINL - 1);
    test_in = 1'b1; step(MINL);
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R4 short low");
  endtask

  task automatic t_short_final();
    prep(0);
    test_in = 1'b1; step(FIRST);
    test_in = 1'b0; step(MINL);
    test_in = 1'b1; step(MINL - 1);
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R2 short final high");
  endtask

  task automatic t_alt();
    prep(1);
    boot_pattern();
    ext_rst_n = 1'b1; step(3);
    drive_pin(0);
    expect_strobe(1, BOOTV, "R6 alt pin boot");
    prep(1);
    test_in = 1'b1; step(FIRST);
    test_in = 1'b0; step(MINL);
    test_in = 1'b1; step(MINL);
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R6 test pin ignored");
    prep(0);
  endtask

  task automatic t_reassert();
    prep(0);
    boot_pattern();
    ext_rst_n = 1'b1; step(4);
    ext_rst_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(dec_stb == 0, "R7 cancelled pending boot", dec_stb, 0);
    end
    ext_rst_n = 1'b1;
    expect_strobe(0, USERV, "R7 count cleared");
  endtask

  task automatic t_after(input logic boot);
    prep(0);
    if (boot) begin
      boot_pattern();
      ext_rst_n = 1'b1; step(3);
      test_in = 1'b0;
      expect_strobe(1, BOOTV, "R8 setup boot");
    end else begin
      ext_rst_n = 1'b1;
      expect_strobe(0, USERV, "R8 setup normal");
    end
    for (int i = 0; i < 6; i++) begin
      test_in = ~test_in; step(5);
      chk(dec_stb == 0, "R8 no strobe after decision", dec_stb, 0);
      chk(boot_sel == boot, "R8 boot_sel held", boot_sel, boot);
      chk(start_addr == (boot ? BOOTV : USERV), "R8 start_addr held", start_addr, boot ? BOOTV : USERV);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset_state();
    t_normal();
    t_boot();
    t_one_rise();
    t_short_first();
    t_short_low();
    t_short_final();
    t_alt();
    t_reassert();
    t_after(0);
    t_after(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule